// File: doc/BRIEF.md
# Four-Channel Shared-Bus Block Mover

This block copies words from one place on a shared address/data bus to another. The CPU normally owns that bus. Each of the four channels keeps its own source pointer, destination pointer, remaining word count and bus-sharing policy. A channel is loaded through a valid/ready configuration port, and a non-zero count arms it.

When a channel is armed and the bus is not owned, the controller raises a hold request. It waits until the CPU returns hold acknowledge, then moves words. Each word takes one read cycle at the source followed by one write cycle at the destination. How long the controller keeps the bus depends on the channel's policy:

- Cycle stealing: the bus is given back after every word.
- Burst: the bus is kept until the block is finished.
- Idle-only: a word is moved only after the CPU has reported the bus idle.

When the last word is written, the channel raises a one-cycle interrupt and a sticky done flag, and the hold request falls.

The configuration port follows valid/ready rules. A word is taken on a clock edge where both `cfg_valid` and `cfg_ready` are high. `cfg_ready` is low while `cfg_chan` names the channel that currently owns the controller. The sender must hold `cfg_valid` and the fields steady until the word is taken.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, `hold_req`, `bus_drive`, `bus_rd`, `bus_wr`, `tc_irq` and `chan_done` are all low, and `cfg_ready` is high.
- R2: A configuration word is taken when `cfg_valid` and `cfg_ready` are both high at a clock edge. Taking it loads that channel and clears its done flag. The channel is armed only when the count is non-zero, so a zero count causes no bus request. `cfg_ready` is low while `cfg_chan` equals the channel currently in service.
- R3: `bus_drive` is high only while `hold_req` is high. It first rises only after `hold_ack` was sampled high on the previous edge, and it is never high while `hold_ack` is low. When `bus_drive` is low, the bus outputs are to be treated as released.
- R4: Each word is moved in two cycles: a read cycle (`bus_rd`) at the source address, then a write cycle (`bus_wr`) at the destination address carrying the word just read. After each word both addresses advance by one and the count falls by one, so exactly `count` words are written.
- R5: Policy code 2'b00 (cycle stealing) drops `hold_req` in the cycle after every write cycle and requests the bus again for the next word. Code 2'b11 behaves the same way.
- R6: Policy code 2'b01 (burst) keeps `hold_req` high from the first word to the last, so one block causes exactly one rising edge of `hold_req`.
- R7: Policy code 2'b10 (idle-only) starts a read cycle only if `cpu_idle` was high on the edge before it. While `cpu_idle` stays low, no word is moved.
- R8: In the cycle after the final write of a channel, that channel's done flag rises and its `tc_irq` bit is high for exactly one cycle. In that same cycle `hold_req` is low.
- R9: Arbitration happens only while the bus is not owned, and it picks the lowest-numbered armed channel. A channel that owns the bus in burst is therefore not pre-empted by a higher-priority channel armed later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_ready | output | 1 | Configuration word can be taken |
| cfg_chan | input | 2 | Channel being configured |
| cfg_src | input | 16 | Start source address |
| cfg_dst | input | 16 | Start destination address |
| cfg_count | input | 16 | Number of words to move |
| cfg_mode | input | 2 | Bus-sharing policy code |
| hold_req | output | 1 | Request for the shared bus |
| hold_ack | input | 1 | CPU has released the bus |
| cpu_idle | input | 1 | CPU reports the bus idle |
| bus_addr | output | 16 | Address while driving |
| bus_wdata | output | 8 | Write data while driving |
| bus_rdata | input | 8 | Read data from the bus |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_drive | output | 1 | Address/data outputs are driven |
| chan_done | output | 4 | Sticky per-channel done flags |
| tc_irq | output | 4 | One-cycle terminal-count interrupts |

## Verification
The copy function is tried with each of the three policies on separate blocks, and the number of hold-request rising edges tells cycle stealing apart from burst. An idle-only block is first held off with `cpu_idle` low and then released, which shows that the gate really stops traffic. Two concurrent patterns separate the two arbitration rules. In the first, a higher-priority channel is armed while a cycle-stealing channel is partway through its block, and it should win at the next release. In the second, the same arming happens during a burst, and it must wait for the burst to finish. A zero-count load and a load aimed at the busy channel exercise the configuration rules.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    XM_STEAL  = 2'b00,
    XM_BURST  = 2'b01,
    XM_IDLEGO = 2'b10,
    XM_ALT    = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_RD,
    ST_WR,
    ST_REL
  } eng_state_e;
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  xfer_mode_e    ld_mode,
  input  logic          step,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output xfer_mode_e    mode,
  output logic          armed,
  output logic          done,
  output logic          last
);
  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src   <= '0;
      dst   <= '0;
      cnt   <= '0;
      mode  <= XM_STEAL;
      armed <= 1'b0;
      done  <= 1'b0;
    end else if (load) begin
      src   <= ld_src;
      dst   <= ld_dst;
      cnt   <= ld_cnt;
      mode  <= ld_mode;
      armed <= (ld_cnt != '0);
      done  <= 1'b0;
    end else if (step) begin
      src <= src + AW'(1);
      dst <= dst + AW'(1);
      cnt <= cnt - CW'(1);
      if (last) begin
        armed <= 1'b0;
        done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [IW-1:0]  idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_any,
  input  logic [IW-1:0] pend_idx,
  input  xfer_mode_e    cur_mode,
  input  logic          cur_last,
  input  logic [AW-1:0] cur_src,
  input  logic [AW-1:0] cur_dst,
  input  logic          hold_ack,
  input  logic          cpu_idle,
  input  logic [DW-1:0] rdata,
  output logic          hold_req,
  output logic          busy,
  output logic [IW-1:0] cur_chan,
  output logic          step,
  output logic          term,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          rd_en,
  output logic          wr_en,
  output logic          drive
);
  eng_state_e    state;
  logic [DW-1:0] hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_chan  <= '0;
      hold_data <= '0;
    end else begin
      case (state)
        ST_IDLE: if (pend_any) begin
          cur_chan <= pend_idx;
          state    <= ST_REQ;
        end
        ST_REQ: if (hold_ack) begin
          state <= (cur_mode == XM_IDLEGO && !cpu_idle) ? ST_WAIT : ST_RD;
        end
        ST_WAIT: if (cpu_idle) state <= ST_RD;
        ST_RD: begin
          hold_data <= rdata;
          state     <= ST_WR;
        end
        ST_WR: begin
          if (cur_last) state <= ST_REL;
          else begin
            case (cur_mode)
              XM_BURST:  state <= ST_RD;
              XM_IDLEGO: state <= ST_WAIT;
              default:   state <= ST_REL;
            endcase
          end
        end
        ST_REL: if (!hold_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    hold_req = (state == ST_REQ) || (state == ST_WAIT) ||
               (state == ST_RD)  || (state == ST_WR);
    busy  = (state != ST_IDLE);
    rd_en = (state == ST_RD);
    wr_en = (state == ST_WR);
    drive = rd_en || wr_en;
    step  = wr_en;
    term  = wr_en && cur_last;
    addr  = rd_en ? cur_src : (wr_en ? cur_dst : '0);
    wdata = wr_en ? hold_data : '0;
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int CW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_valid,
  output logic           cfg_ready,
  input  logic [IW-1:0]  cfg_chan,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_count,
  input  logic [1:0]     cfg_mode,
  output logic           hold_req,
  input  logic           hold_ack,
  input  logic           cpu_idle,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic           bus_drive,
  output logic [NCH-1:0] chan_done,
  output logic [NCH-1:0] tc_irq
);
  logic [AW-1:0] slot_src [NCH];
  logic [AW-1:0] slot_dst [NCH];
  xfer_mode_e    slot_mode [NCH];
  logic [NCH-1:0] slot_armed, slot_last;
  logic          pend_any, eng_busy, eng_step, eng_term;
  logic [IW-1:0] pend_idx, cur_chan;
  xfer_mode_e    cur_mode;
  logic          cfg_take;

  assign cfg_ready = !(eng_busy && (cfg_chan == cur_chan));
  assign cfg_take  = cfg_valid && cfg_ready;
  assign cur_mode  = slot_mode[cur_chan];

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    dma_chan_slot #(.AW(AW), .CW(CW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cfg_take && (cfg_chan == IW'(g))),
      .ld_src (cfg_src),
      .ld_dst (cfg_dst),
      .ld_cnt (cfg_count),
      .ld_mode(xfer_mode_e'(cfg_mode)),
      .step   (eng_step && (cur_chan == IW'(g))),
      .src    (slot_src[g]),
      .dst    (slot_dst[g]),
      .mode   (slot_mode[g]),
      .armed  (slot_armed[g]),
      .done   (chan_done[g]),
      .last   (slot_last[g])
    );
  end

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .req(slot_armed),
    .any(pend_any),
    .idx(pend_idx)
  );

  dma_engine #(.NCH(NCH), .AW(AW), .DW(DW)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_any(pend_any),
    .pend_idx(pend_idx),
    .cur_mode(cur_mode),
    .cur_last(slot_last[cur_chan]),
    .cur_src (slot_src[cur_chan]),
    .cur_dst (slot_dst[cur_chan]),
    .hold_ack(hold_ack),
    .cpu_idle(cpu_idle),
    .rdata   (bus_rdata),
    .hold_req(hold_req),
    .busy    (eng_busy),
    .cur_chan(cur_chan),
    .step    (eng_step),
    .term    (eng_term),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rd_en   (bus_rd),
    .wr_en   (bus_wr),
    .drive   (bus_drive)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_irq <= '0;
    else begin
      tc_irq <= '0;
      if (eng_term) tc_irq[cur_chan] <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hold_req,
  input logic           hold_ack,
  input logic           cpu_idle,
  input logic           bus_drive,
  input logic           bus_rd,
  input logic           bus_wr,
  input logic [NCH-1:0] tc_irq,
  input logic [1:0]     eng_mode
);
  a_r3_drive_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> hold_req);
  a_r3_drive_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive) |-> $past(hold_ack));
  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_wr);
  a_r4_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  a_r5_steal_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (eng_mode == 2'b00 || eng_mode == 2'b11)) |=> !hold_req);
  a_r7_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && eng_mode == 2'b10) |-> $past(cpu_idle));
  a_r8_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_irq));
  a_r8_irq_drops_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_irq) |-> !hold_req);
endmodule

bind dma_ctrl dma_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold_req (hold_req),
  .hold_ack (hold_ack),
  .cpu_idle (cpu_idle),
  .bus_drive(bus_drive),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .tc_irq   (tc_irq),
  .eng_mode (cur_mode)
);

// File: tb/sim_dma_ctrl.sv
`timescale 1ns/1ps
module sim_dma_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [1:0]  cfg_chan = '0;
  logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_count = '0;
  logic [1:0]  cfg_mode = '0;
  logic        hold_req, hold_ack = 1'b0, cpu_idle = 1'b1;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_rd, bus_wr, bus_drive;
  logic [3:0]  chan_done, tc_irq;

  logic [7:0]  mem [256];
  int          n_tests = 0, n_fail = 0;
  int          cyc = 0, hrq_rises = 0, r3_bad = 0;
  int          irq_cnt [4];
  int          done_at [4];
  logic        prev_hrq = 1'b0;
  logic [3:0]  prev_done = '0;
  bit          finished = 0;

  always #5 clk = ~clk;

  dma_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_chan(cfg_chan), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .cfg_mode(cfg_mode), .hold_req(hold_req),
    .hold_ack(hold_ack), .cpu_idle(cpu_idle), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_drive(bus_drive), .chan_done(chan_done),
    .tc_irq(tc_irq)
  );

  // CPU side: grants the bus one edge after the request and memory answers at once
  assign bus_rdata = mem[bus_addr[7:0]];
  always @(posedge clk) begin
    hold_ack <= hold_req;
    if (bus_wr && bus_drive) mem[bus_addr[7:0]] <= bus_wdata;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (hold_req && !prev_hrq) hrq_rises <= hrq_rises + 1;
    prev_hrq <= hold_req;
    if (bus_drive && !hold_ack) r3_bad <= r3_bad + 1;
    for (int i = 0; i < 4; i++) begin
      if (tc_irq[i]) irq_cnt[i] <= irq_cnt[i] + 1;
      if (chan_done[i] && !prev_done[i]) done_at[i] <= cyc;
    end
    prev_done <= chan_done;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cfg(input int ch, input int src, input int dst, input int cnt, input int md);
    @(negedge clk);
    cfg_chan = 2'(ch); cfg_src = 16'(src); cfg_dst = 16'(dst);
    cfg_count = 16'(cnt); cfg_mode = 2'(md); cfg_valid = 1'b1;
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic wait_done(input int ch);
    for (int k = 0; k < 2000 && !chan_done[ch]; k++) @(negedge clk);
  endtask

  task automatic clear_counts();
    @(negedge clk);
    hrq_rises = 0;
    for (int i = 0; i < 4; i++) irq_cnt[i] = 0;
  endtask

  task automatic check_copy(input string req, input int src, input int dst, input int cnt);
    int bad = 0;
    for (int i = 0; i < cnt; i++) if (mem[dst+i] !== mem[src+i]) bad++;
    check(bad == 0, req, bad, 0);
    check(mem[dst+cnt] === 8'h00, req, int'(mem[dst+cnt]), 0);
  endtask

  task automatic t_reset();
    check(hold_req == 0 && bus_drive == 0, "R1", int'({hold_req, bus_drive}), 0);
    check(bus_rd == 0 && bus_wr == 0, "R1", int'({bus_rd, bus_wr}), 0);
    check(chan_done == 0 && tc_irq == 0, "R1", int'({chan_done, tc_irq}), 0);
    check(cfg_ready == 1, "R1", int'(cfg_ready), 1);
  endtask

  task automatic t_steal();
    clear_counts();
    do_cfg(1, 8'h10, 8'h40, 3, 0);
    wait_done(1);
    repeat (4) @(negedge clk);
    check_copy("R4", 8'h10, 8'h40, 3);
    check(hrq_rises == 3, "R5", hrq_rises, 3);
    check(chan_done[1] == 1, "R8", int'(chan_done[1]), 1);
    check(irq_cnt[1] == 1, "R8", irq_cnt[1], 1);
  endtask

  task automatic t_burst();
    clear_counts();
    do_cfg(2, 8'h20, 8'h60, 5, 1);
    wait_done(2);
    check(hold_req == 0 && tc_irq[2] == 1, "R8", int'({hold_req, tc_irq[2]}), 1);
    repeat (4) @(negedge clk);
    check(tc_irq == 0, "R8", int'(tc_irq), 0);
    check_copy("R4", 8'h20, 8'h60, 5);
    check(hrq_rises == 1, "R6", hrq_rises, 1);
  endtask

  task automatic t_idle_only();
    clear_counts();
    cpu_idle = 1'b0;
    do_cfg(3, 8'h30, 8'h80, 3, 2);
    repeat (20) @(negedge clk);
    check(mem[8'h80] === 8'h00, "R7", int'(mem[8'h80]), 0);
    check(chan_done[3] == 0, "R7", int'(chan_done[3]), 0);
    check(hold_req == 1, "R7", int'(hold_req), 1);
    cpu_idle = 1'b1;
    wait_done(3);
    repeat (4) @(negedge clk);
    check_copy("R7", 8'h30, 8'h80, 3);
  endtask

  task automatic t_prio_steal();
    do_cfg(2, 8'h00, 8'hA0, 2, 0);
    do_cfg(0, 8'h08, 8'hB0, 2, 0);
    wait_done(0);
    wait_done(2);
    repeat (4) @(negedge clk);
    check(done_at[0] < done_at[2], "R9", done_at[0], done_at[2]);
    check_copy("R9", 8'h08, 8'hB0, 2);
  endtask

  task automatic t_no_preempt();
    do_cfg(3, 8'h00, 8'hC0, 8, 1);
    repeat (3) @(negedge clk);
    cfg_chan = 2'd3; cfg_src = 16'h0050; cfg_dst = 16'h00E0; cfg_count = 16'd1;
    cfg_mode = 2'd0; cfg_valid = 1'b1;
    #1;
    check(cfg_ready == 0, "R2", int'(cfg_ready), 0);
    @(negedge clk);
    cfg_valid = 1'b0;
    do_cfg(0, 8'h10, 8'hD0, 1, 0);
    wait_done(3);
    wait_done(0);
    repeat (4) @(negedge clk);
    check(done_at[3] < done_at[0], "R9", done_at[3], done_at[0]);
    check_copy("R2", 8'h00, 8'hC0, 8);
  endtask

  task automatic t_zero_count();
    clear_counts();
    do_cfg(1, 8'h10, 8'hF0, 0, 1);
    repeat (10) @(negedge clk);
    check(hrq_rises == 0, "R2", hrq_rises, 0);
    check(chan_done[1] == 0, "R2", int'(chan_done[1]), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i < 64) ? 8'((i * 37 + 11) | 1) : 8'h00;
    for (int i = 0; i < 4; i++) begin irq_cnt[i] = 0; done_at[i] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_steal();
    t_burst();
    t_idle_only();
    t_prio_steal();
    t_no_preempt();
    t_zero_count();
    check(r3_bad == 0, "R3", r3_bad, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule